// File: doc/BRIEF.md
# Dual-Redundant Self-Checking Adder

This block is an add/subtract functional unit that runs every operation on two identical adder lanes, a prime lane and a spare lane, and compares the two sums. When they agree, the prime sum is posted. When they disagree, the unit holds the operation by raising `busy` and runs it again on the next cycle. A disagreement that lasts for `PERSIST` consecutive cycles is treated as a permanent fault. The unit then spends one cycle recomputing with every adder input inverted, which lets it judge each lane on its own.

In the recompute cycle both lanes receive the inverted first operand, the inverted second operand and the inverted carry-in. A healthy lane then produces the bitwise complement of its normal sum. A lane whose last normal sum is not the complement of its recomputed sum is flagged as faulty. A stuck output bit at any position breaks this complement relation, so this test exposes it. Exactly one flagged lane is isolated for good and the other lane serves all later operations with no comparison. If no lane or both lanes are flagged, the unit cannot be trusted. It posts zero for every later operation and holds its interrupt request high until reset.

Subtraction is carried out as the first operand plus the inverted second operand plus one. It uses the same compare, retry and recompute path as addition. Each lane has force-high and force-low masks on its output so that stuck-at faults can be modelled. The states are:
- PAIR: both lanes run and are compared.
- CHECK: the recompute cycle.
- SOLO_PRIME: the prime lane only.
- SOLO_SPARE: the spare lane only.
- HALT: the unit is untrusted.

The transitions are:
- PAIR→CHECK on the `PERSIST`-th consecutive mismatch.
- CHECK→SOLO_SPARE when only the prime lane is flagged.
- CHECK→SOLO_PRIME when only the spare lane is flagged.
- CHECK→HALT otherwise.
- Reset returns the unit to PAIR.

Top module: `dmr_adder`

## Requirements
- R1: An operation is accepted in a cycle with `op_valid` high and `busy` low. One clock later `res_valid` is high and `res_data` holds (`op_a` + `op_b`) mod 2^WIDTH when `op_sub`=0.
- R2: While the two lane sums differ in PAIR state, `busy` is high and no result is posted. If the lanes agree on a later retry of the held operation, the correct sum is posted and the unit stays in PAIR. A mismatch that lasts k < PERSIST cycles gives exactly k busy cycles.
- R3: A mismatch that lasts PERSIST consecutive cycles moves the unit to the CHECK state. `busy` stays high through CHECK, for PERSIST+1 busy cycles in total, and never for longer.
- R4: In CHECK, each lane receives its inverted adder inputs including the carry-in. A lane is flagged when its last normal sum differs from the complement of its recomputed sum. Flags are sticky until reset.
- R5: If only the prime lane is flagged, the spare lane's sum is posted for the held operation and for all later operations, with `busy` low and `irq` low.
- R6: If only the spare lane is flagged, the prime lane's sum is posted for the held operation and for all later operations, with `busy` low and `irq` low.
- R7: If no lane or both lanes are flagged, the held operation and all later operations post `res_data` = 0. `irq` is high from then until reset.
- R8: With `op_sub`=1 the result is (`op_a` - `op_b`) mod 2^WIDTH. Subtraction goes through the same retry and recompute path as addition.
- R9: After reset, `res_valid`, `busy` and `irq` are low and the unit is in PAIR.
- R10: Once a lane is isolated, forced faults on that lane have no effect on the posted results and never raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present; held by the upstream logic while `busy` is high |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| prime_force_hi | input | WIDTH | Prime lane output bits forced to 1 (fault model) |
| prime_force_lo | input | WIDTH | Prime lane output bits forced to 0 (fault model) |
| spare_force_hi | input | WIDTH | Spare lane output bits forced to 1 (fault model) |
| spare_force_lo | input | WIDTH | Spare lane output bits forced to 0 (fault model) |
| busy | output | 1 | Operation not accepted this cycle (retry or recompute) |
| res_valid | output | 1 | Result posted |
| res_data | output | WIDTH | Posted result |
| irq | output | 1 | Unit untrusted; level held until reset |

## Verification
The bench builds the unit with WIDTH=8 and PERSIST=3. At this width every addition pair can be swept in a single pass, and a third of all subtraction pairs as well. Fault scenarios use glitches timed to the cycle on the prime lane to reach each CHECK outcome. A glitch of one or two cycles tests retry only. A three-cycle glitch isolates the prime lane. If the forced polarity is reversed during the CHECK cycle, neither lane gets flagged. Permanent faults on both lanes get both flagged. PERSIST=3 keeps each escalation to four busy cycles, so the bounds of the busy window can be checked exactly.

// File: rtl/dmr_adder_pkg.sv
package dmr_adder_pkg;
    typedef enum logic [2:0] {
        ST_PAIR,
        ST_CHECK,
        ST_SOLO_PRIME,
        ST_SOLO_SPARE,
        ST_HALT
    } unit_state_e;

    localparam int LANE_PRIME = 0;
    localparam int LANE_SPARE = 1;
    localparam int NUM_LANES  = 2;
endpackage

// File: rtl/dmr_adder_lane.sv
module dmr_adder_lane #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    input  logic [WIDTH-1:0] force_hi_i,
    input  logic [WIDTH-1:0] force_lo_i,
    output logic [WIDTH-1:0] sum_o
);
    logic [WIDTH-1:0] raw_sum;

    assign raw_sum = x_i + y_i + {{(WIDTH-1){1'b0}}, cin_i};
    // stuck-at fault model on the lane output
    assign sum_o   = (raw_sum | force_hi_i) & ~force_lo_i;
endmodule

// File: rtl/dmr_adder_opnd.sv
module dmr_adder_opnd #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    input  logic             op_sub_i,
    input  logic             recompute_i,
    output logic [WIDTH-1:0] x_o,
    output logic [WIDTH-1:0] y_o,
    output logic             cin_o
);
    logic [WIDTH-1:0] y_norm;

    // subtraction: a + ~b + 1
    assign y_norm = op_sub_i ? ~op_b_i : op_b_i;

    // recompute: ~x + ~y + ~cin == ~(x + y + cin)
    assign x_o   = recompute_i ? ~op_a_i  : op_a_i;
    assign y_o   = recompute_i ? ~y_norm  : y_norm;
    assign cin_o = recompute_i ? ~op_sub_i : op_sub_i;
endmodule

// File: rtl/dmr_adder_ctrl.sv
module dmr_adder_ctrl
    import dmr_adder_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int PERSIST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid_i,
    input  logic [WIDTH-1:0] sum_prime_i,
    input  logic [WIDTH-1:0] sum_spare_i,
    output logic             recompute_o,
    output logic             busy_o,
    output logic             irq_o,
    output logic             res_valid_o,
    output logic [WIDTH-1:0] res_data_o,
    output unit_state_e      state_o
);
    localparam int CNT_W = $clog2(PERSIST + 1);
    localparam logic [CNT_W-1:0] LAST_RETRY = CNT_W'(PERSIST - 1);

    unit_state_e      state_q, state_d;
    logic [CNT_W-1:0] miss_cnt_q;
    logic [WIDTH-1:0] norm_prime_q, norm_spare_q;
    logic             flag_prime_q, flag_spare_q;
    logic             mismatch, accept;
    logic             bad_prime, bad_spare, flag_prime_d, flag_spare_d;

    assign mismatch  = (sum_prime_i != sum_spare_i);
    // valid only in CHECK, where lanes carry the recomputed sums
    assign bad_prime = (norm_prime_q != ~sum_prime_i);
    assign bad_spare = (norm_spare_q != ~sum_spare_i);
    assign flag_prime_d = flag_prime_q | bad_prime;
    assign flag_spare_d = flag_spare_q | bad_spare;
    assign accept    = op_valid_i & ~busy_o;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PAIR: begin
                if (op_valid_i && mismatch && (miss_cnt_q == LAST_RETRY))
                    state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (flag_prime_d && !flag_spare_d)
                    state_d = ST_SOLO_SPARE;
                else if (!flag_prime_d && flag_spare_d)
                    state_d = ST_SOLO_PRIME;
                else
                    state_d = ST_HALT;
            end
            ST_SOLO_PRIME, ST_SOLO_SPARE, ST_HALT: state_d = state_q;
            default: state_d = ST_HALT;
        endcase
    end

    // state register and fault bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_PAIR;
            miss_cnt_q   <= '0;
            norm_prime_q <= '0;
            norm_spare_q <= '0;
            flag_prime_q <= 1'b0;
            flag_spare_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PAIR) begin
                if (op_valid_i && mismatch) begin
                    miss_cnt_q   <= miss_cnt_q + CNT_W'(1);
                    norm_prime_q <= sum_prime_i;
                    norm_spare_q <= sum_spare_i;
                end else if (accept) begin
                    miss_cnt_q <= '0;
                end
            end
            if (state_q == ST_CHECK) begin
                flag_prime_q <= flag_prime_d;
                flag_spare_q <= flag_spare_d;
                miss_cnt_q   <= '0;
            end
        end
    end

    // combinational outputs
    always_comb begin
        recompute_o = (state_q == ST_CHECK);
        irq_o       = (state_q == ST_HALT);
        unique case (state_q)
            ST_PAIR:  busy_o = op_valid_i & mismatch;
            ST_CHECK: busy_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
    end

    // registered result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            res_data_o  <= '0;
        end else begin
            res_valid_o <= accept;
            if (accept) begin
                unique case (state_q)
                    ST_PAIR, ST_SOLO_PRIME: res_data_o <= sum_prime_i;
                    ST_SOLO_SPARE:          res_data_o <= sum_spare_i;
                    default:                res_data_o <= '0;
                endcase
            end
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/dmr_adder.sv
module dmr_adder
    import dmr_adder_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int PERSIST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_sub,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] prime_force_hi,
    input  logic [WIDTH-1:0] prime_force_lo,
    input  logic [WIDTH-1:0] spare_force_hi,
    input  logic [WIDTH-1:0] spare_force_lo,
    output logic             busy,
    output logic             res_valid,
    output logic [WIDTH-1:0] res_data,
    output logic             irq
);
    logic [WIDTH-1:0] lane_x, lane_y;
    logic             lane_cin, recompute;
    logic [NUM_LANES-1:0][WIDTH-1:0] force_hi, force_lo, lane_sum;
    unit_state_e      unit_state;

    assign force_hi[LANE_PRIME] = prime_force_hi;
    assign force_lo[LANE_PRIME] = prime_force_lo;
    assign force_hi[LANE_SPARE] = spare_force_hi;
    assign force_lo[LANE_SPARE] = spare_force_lo;

    dmr_adder_opnd #(.WIDTH(WIDTH)) opnd_i (
        .op_a_i      (op_a),
        .op_b_i      (op_b),
        .op_sub_i    (op_sub),
        .recompute_i (recompute),
        .x_o         (lane_x),
        .y_o         (lane_y),
        .cin_o       (lane_cin)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dmr_adder_lane #(.WIDTH(WIDTH)) lane_i (
            .x_i        (lane_x),
            .y_i        (lane_y),
            .cin_i      (lane_cin),
            .force_hi_i (force_hi[g]),
            .force_lo_i (force_lo[g]),
            .sum_o      (lane_sum[g])
        );
    end

    dmr_adder_ctrl #(.WIDTH(WIDTH), .PERSIST(PERSIST)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid_i  (op_valid),
        .sum_prime_i (lane_sum[LANE_PRIME]),
        .sum_spare_i (lane_sum[LANE_SPARE]),
        .recompute_o (recompute),
        .busy_o      (busy),
        .irq_o       (irq),
        .res_valid_o (res_valid),
        .res_data_o  (res_data),
        .state_o     (unit_state)
    );
endmodule

// File: rtl/dmr_adder_chk.sv
module dmr_adder_chk
    import dmr_adder_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int PERSIST = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             busy,
    input logic             res_valid,
    input logic [WIDTH-1:0] res_data,
    input logic             irq,
    input unit_state_e      state_i
);
    localparam int RUN_W = $clog2(PERSIST + 3);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PERSIST + 2);

    logic [RUN_W-1:0] busy_run_q;

    // consecutive busy cycles seen before the current one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_run_q <= '0;
        else if (!busy)
            busy_run_q <= '0;
        else if (busy_run_q != RUN_MAX)
            busy_run_q <= busy_run_q + RUN_W'(1);
    end

    a_r1_post_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(op_valid && !busy));

    a_r2_no_post_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && busy) |=> !res_valid);

    a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run_q <= RUN_W'(PERSIST)));

    a_r5_spare_isolation_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_SOLO_SPARE) |=> (state_i == ST_SOLO_SPARE));

    a_r6_prime_isolation_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_SOLO_PRIME) |=> (state_i == ST_SOLO_PRIME));

    a_r7_halt_posts_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && res_valid) |-> (res_data == '0));

    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> irq);

    a_r10_isolated_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_i == ST_SOLO_PRIME) || (state_i == ST_SOLO_SPARE)) |-> !busy);
endmodule

bind dmr_adder dmr_adder_chk #(.WIDTH(WIDTH), .PERSIST(PERSIST)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .busy      (busy),
    .res_valid (res_valid),
    .res_data  (res_data),
    .irq       (irq),
    .state_i   (unit_state)
);

// File: tb/dmr_adder_tb.sv
module dmr_adder_tb_top;
    localparam int W = 8;
    localparam int P = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic         op_valid = 1'b0, op_sub = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [W-1:0] p_hi_perm = '0, p_lo_perm = '0, s_hi_perm = '0, s_lo_perm = '0;
    logic [W-1:0] p_hi_gl = '0, p_lo_gl = '0;
    logic         busy, res_valid, irq;
    logic [W-1:0] res_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    dmr_adder #(.WIDTH(W), .PERSIST(P)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .op_valid       (op_valid),
        .op_sub         (op_sub),
        .op_a           (op_a),
        .op_b           (op_b),
        .prime_force_hi (p_hi_perm | p_hi_gl),
        .prime_force_lo (p_lo_perm | p_lo_gl),
        .spare_force_hi (s_hi_perm),
        .spare_force_lo (s_lo_perm),
        .busy           (busy),
        .res_valid      (res_valid),
        .res_data       (res_data),
        .irq            (irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected<190000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        op_valid = 1'b0;
        p_hi_perm = '0; p_lo_perm = '0; s_hi_perm = '0; s_lo_perm = '0;
        p_hi_gl = '0; p_lo_gl = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // hold one operation; prime lane glitches forced-high for k_hi cycles,
    // then forced-low for k_lo cycles; counts busy cycles
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                          input int k_hi, input logic [W-1:0] m_hi,
                          input int k_lo, input logic [W-1:0] m_lo,
                          output logic [W-1:0] r, output logic v,
                          output logic irq_o, output int bc);
        @(negedge clk);
        op_a = a; op_b = b; op_sub = s; op_valid = 1'b1; bc = 0;
        p_hi_gl = m_hi;
        for (int i = 0; i < k_hi; i++) begin
            #1; if (busy) bc++;
            @(negedge clk);
        end
        p_hi_gl = '0;
        p_lo_gl = m_lo;
        for (int i = 0; i < k_lo; i++) begin
            #1; if (busy) bc++;
            @(negedge clk);
        end
        p_lo_gl = '0;
        #1;
        while (busy && bc < 40) begin
            bc++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        op_valid = 1'b0;
        r = res_data; v = res_valid; irq_o = irq;
    endtask

    logic [W-1:0] r, exp_v;
    logic         v, iq, pend;
    int           bc;

    initial begin
        // R9 reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 busy in reset", busy, 0);
        check("R9 res_valid in reset", res_valid, 0);
        check("R9 irq in reset", irq, 0);
        do_reset();
        check("R9 busy after reset", busy, 0);
        check("R9 irq after reset", irq, 0);

        // R1 exhaustive addition sweep, one op per cycle
        pend = 1'b0; exp_v = '0;
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                @(negedge clk);
                if (pend) check("R1 add sweep", {res_valid, res_data}, {1'b1, exp_v});
                op_a = W'(a); op_b = W'(b); op_sub = 1'b0; op_valid = 1'b1;
                exp_v = W'(a + b); pend = 1'b1;
            end
        end
        // R8 subtraction sweep
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 3) begin
                @(negedge clk);
                if (pend) check("R8 sweep result", {res_valid, res_data}, {1'b1, exp_v});
                op_a = W'(a); op_b = W'(b); op_sub = 1'b1; op_valid = 1'b1;
                exp_v = W'(a - b); pend = 1'b1;
            end
        end
        @(negedge clk);
        check("R8 last sweep result", {res_valid, res_data}, {1'b1, exp_v});
        op_valid = 1'b0;

        // R2 transient mismatches
        run_op(8'd3, 8'd4, 1'b0, 1, 8'h80, 0, 8'h00, r, v, iq, bc);
        check("R2 one-cycle glitch busy count", bc, 1);
        check("R2 one-cycle glitch result", {v, r}, {1'b1, 8'd7});
        run_op(8'd3, 8'd4, 1'b0, 2, 8'h80, 0, 8'h00, r, v, iq, bc);
        check("R2 two-cycle glitch busy count", bc, 2);
        check("R2 two-cycle glitch result", {v, r}, {1'b1, 8'd7});
        run_op(8'd9, 8'd2, 1'b1, 2, 8'h80, 0, 8'h00, r, v, iq, bc);
        check("R8 sub retry busy count", bc, 2);
        check("R8 sub retry result", {v, r}, {1'b1, 8'd7});
        run_op(8'd40, 8'd2, 1'b0, 0, 8'h00, 0, 8'h00, r, v, iq, bc);
        check("R2 still paired after retries", bc, 0);
        check("R2 still paired result", r, 42);
        check("R2 no irq after retries", iq, 0);

        // R3/R4/R5 persistent prime fault -> prime isolated
        do_reset();
        run_op(8'd3, 8'd4, 1'b0, 3, 8'h80, 0, 8'h00, r, v, iq, bc);
        check("R3 escalation busy count", bc, P + 1);
        check("R5 result from spare", {v, r}, {1'b1, 8'd7});
        check("R5 no irq", iq, 0);
        p_hi_perm = 8'hFF;
        run_op(8'd10, 8'd20, 1'b0, 0, 8'h00, 0, 8'h00, r, v, iq, bc);
        check("R10 isolated prime fault ignored", {v, r}, {1'b1, 8'd30});
        check("R10 no busy after isolation", bc, 0);
        p_hi_perm = 8'h00; p_lo_perm = 8'hFF;
        run_op(8'd200, 8'd100, 1'b0, 0, 8'h00, 0, 8'h00, r, v, iq, bc);
        check("R5 spare serves later op", {v, r}, {1'b1, 8'd44});
        check("R10 no busy on forced-low prime", bc, 0);

        // R4/R7 neither flagged -> halt
        do_reset();
        run_op(8'd3, 8'd4, 1'b0, 3, 8'h80, 1, 8'h80, r, v, iq, bc);
        check("R7 neither flagged busy count", bc, P + 1);
        check("R7 neither flagged posts zero", {v, r}, {1'b1, 8'd0});
        check("R7 neither flagged irq", iq, 1);
        run_op(8'd1, 8'd1, 1'b0, 0, 8'h00, 0, 8'h00, r, v, iq, bc);
        check("R7 later op posts zero", {v, r}, {1'b1, 8'd0});
        check("R7 irq held", iq, 1);

        // R6/R8 persistent spare fault on subtraction -> spare isolated
        do_reset();
        check("R9 irq cleared by reset", irq, 0);
        s_lo_perm = 8'h01;
        run_op(8'd5, 8'd4, 1'b1, 0, 8'h00, 0, 8'h00, r, v, iq, bc);
        check("R8 sub escalation busy count", bc, P + 1);
        check("R6 result from prime", {v, r}, {1'b1, 8'd1});
        check("R6 no irq", iq, 0);
        s_hi_perm = 8'hFF;
        run_op(8'd100, 8'd27, 1'b0, 0, 8'h00, 0, 8'h00, r, v, iq, bc);
        check("R6 prime serves later op", {v, r}, {1'b1, 8'd127});
        check("R10 isolated spare fault ignored", bc, 0);

        // R4/R7 both lanes faulty -> halt
        do_reset();
        p_hi_perm = 8'h80; s_lo_perm = 8'h01;
        run_op(8'd1, 8'd0, 1'b0, 0, 8'h00, 0, 8'h00, r, v, iq, bc);
        check("R4 both flagged busy count", bc, P + 1);
        check("R7 both flagged posts zero", {v, r}, {1'b1, 8'd0});
        check("R7 both flagged irq", iq, 1);

        do_reset();
        check("R9 final reset busy", busy, 0);
        check("R9 final reset irq", irq, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule